// File: doc/BRIEF.md
# Fixed-Head Disk Controller Status and Interrupt Register

This block is the host-facing register file of a fixed-head disk controller. It holds a 12-bit status word and a 20-bit disk word address, decodes the host's three-bit I/O pulse field for each of four opcode groups, and drives one interrupt request. The host uses it to assemble a disk address in two halves, to start a read or write, to set the interrupt enables and the memory-extension field, and to test done, error and rotational-position conditions by skipping.

The transfer engine outside this block watches `start_o` and `func_o`. It reports back through one-cycle strobes that set done or one of the error bits. A photocell input marks the start of a revolution. The interrupt is the OR of three separately enabled sources: done, the error group and the photocell. The disk address is a flat word index: the low 11 bits select the word within a track, the next 7 bits select the track, and the top 2 bits select the platter.

All pulse responses (`acc_o`, `skip_o`) are combinational in the cycle the group is selected. Register updates take effect at the next rising clock edge.

Top module: `dkc_status_ctl`

## Requirements
- R1: After reset the status word reads 0, both address halves read 0, done is set (group-2 done skip returns 1) and `irq_o` is low.
- R2: Group 0 with pulse bit 0 clears the low 12 address bits, clears done and clears every error bit. The error bits are write-lock (status bit 9, octal 1000), data-late (bit 2, octal 0004), no-disk (bit 1, octal 0002) and parity (bit 0, octal 0001).
- R3: Group 0 with pulse bit 1 or bit 2 ORs `acc_i` into the low 12 address bits and returns `acc_o`=0. In the next cycle, and only then, `start_o` is high with `func_o`={pulse bit 2, pulse bit 1, 0}: 3'd2 means read and 3'd4 means write.
- R4: Group 1 pulse 1 clears status bits 8:3 and keeps the rest. `irq_o` is low afterwards, and `acc_o` passes `acc_i`.
- R5: Group 1 pulse 5 loads status bits 8:3 from `acc_i[8:3]` and returns 0. Group 1 pulse 6 returns the whole status word. The enable bits are error enable (bit 8, 0400), photocell enable (bit 7, 0200), done enable (bit 6, 0100) and memory extension (bits 5:3).
- R6: Group 1 pulse 2 skips exactly when address bits 10:0 equal `rot_pos_i`. Address bit 11 does not take part.
- R7: Group 2 skips if pulse bit 0 is set and any error is set, or if pulse bit 1 is set, pulse bit 2 is clear and done is set. With pulse bit 2 set, `acc_o` is the low 12 address bits.
- R8: Group 3 pulse 1 clears address bits 19:12. Pulse 3 replaces them with `acc_i[7:0]` and pulse 2 ORs `acc_i[7:0]` into them; both return 0. Pulse 5 returns the 8 bits zero-extended, and pulse 4 returns `acc_i` ORed with them.
- R9: After any group-3 pulse the no-disk bit equals (address >= (`plat_sel_i`+1) x 2^18). Between group-3 pulses it does not follow `plat_sel_i`.
- R10: `irq_o` = (done and done enable) or (any error and error enable) or (photocell bit and photocell enable).
- R11: Status bit 11 (octal 4000) shows `pcell_i` as sampled at the previous clock edge.
- R12: The done and error strobes set their bits. When a strobe and a clear hit in the same cycle, the strobe wins.
- R13: With no group selected, or with a pulse value its group does not decode, `acc_o` equals `acc_i`, `skip_o` is 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 4 | One-hot opcode group select |
| pulse_i | input | 3 | I/O pulse field |
| acc_i | input | 12 | Accumulator from host |
| plat_sel_i | input | 2 | Number of platters minus one |
| rot_pos_i | input | 11 | Current rotational word position |
| pcell_i | input | 1 | Photocell active |
| err_wlock_i | input | 1 | Set write-lock error |
| err_late_i | input | 1 | Set data-late error |
| err_nodisk_i | input | 1 | Set no-disk error |
| err_parity_i | input | 1 | Set parity error |
| done_set_i | input | 1 | Transfer finished, set done |
| acc_o | output | 12 | Accumulator result |
| skip_o | output | 1 | Skip condition |
| start_o | output | 1 | One-cycle transfer start |
| func_o | output | 3 | Function code: 2 read, 4 write |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default geometry: 11 word bits, 7 track bits and 2 platter bits. With this geometry the full 8-bit upper address and all four platter counts can be swept together, so every boundary of the no-disk comparison gets checked. The 11-bit rotational position is swept completely against one fixed address. All 64 combinations of the three interrupt enables and the three interrupt sources are applied and checked against the interrupt formula.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int STA_W = 12;

  // Status bit positions; host software depends on these
  localparam int B_PCELL  = 11;
  localparam int B_WLOCK  = 9;
  localparam int B_EN_ERR = 8;
  localparam int B_EN_PC  = 7;
  localparam int B_EN_DN  = 6;
  localparam int B_LATE   = 2;
  localparam int B_NODISK = 1;
  localparam int B_PARITY = 0;

  localparam logic [STA_W-1:0] ERR_MASK = 12'o1007;

  localparam logic [2:0] FN_READ  = 3'd2;
  localparam logic [2:0] FN_WRITE = 3'd4;

  typedef struct packed {
    logic       clr_lo;
    logic       or_lo;
    logic       start;
    logic [2:0] func;
    logic       clr_errdone;
    logic       clr_en;
    logic       ld_en;
    logic       clr_hi;
    logic       or_hi;
    logic       chk_cap;
  } ctl_t;
endpackage

// File: rtl/dkc_pulse_dec.sv
module dkc_pulse_dec
  import dkc_pkg::*;
#(
  parameter int LO_W = 12,
  parameter int HI_W = 8
) (
  input  logic [3:0]       sel_i,
  input  logic [2:0]       pulse_i,
  input  logic [LO_W-1:0]  acc_i,
  input  logic [STA_W-1:0] sta_i,
  input  logic             done_i,
  input  logic [LO_W-1:0]  da_lo_i,
  input  logic [HI_W-1:0]  da_hi_i,
  input  logic             pos_match_i,
  output ctl_t             ctl_o,
  output logic [LO_W-1:0]  acc_o,
  output logic             skip_o
);
  localparam int PAD_W = LO_W - HI_W;

  logic            err_any;
  logic [LO_W-1:0] hi_ext;

  assign err_any = |(sta_i & ERR_MASK);
  assign hi_ext  = {{PAD_W{1'b0}}, da_hi_i};

  always_comb begin
    ctl_o  = '0;
    acc_o  = acc_i;
    skip_o = 1'b0;
    if (sel_i[0]) begin
      if (pulse_i[0]) begin
        ctl_o.clr_lo      = 1'b1;
        ctl_o.clr_errdone = 1'b1;
      end
      if (pulse_i[1] || pulse_i[2]) begin
        ctl_o.or_lo = 1'b1;
        ctl_o.start = 1'b1;
        ctl_o.func  = {pulse_i[2], pulse_i[1], 1'b0};
        acc_o       = '0;
      end
    end else if (sel_i[1]) begin
      unique case (pulse_i)
        3'd1: ctl_o.clr_en = 1'b1;
        3'd2: skip_o = pos_match_i;
        3'd5: begin
          ctl_o.ld_en = 1'b1;
          acc_o       = '0;
        end
        3'd6: acc_o = sta_i;
        default: ;
      endcase
    end else if (sel_i[2]) begin
      skip_o = (pulse_i[0] && err_any) ||
               (pulse_i[1] && !pulse_i[2] && done_i);
      if (pulse_i[2]) acc_o = da_lo_i;
    end else if (sel_i[3]) begin
      ctl_o.chk_cap = 1'b1;
      unique case (pulse_i)
        3'd1: ctl_o.clr_hi = 1'b1;
        3'd2: begin
          ctl_o.or_hi = 1'b1;
          acc_o       = '0;
        end
        3'd3: begin
          ctl_o.clr_hi = 1'b1;
          ctl_o.or_hi  = 1'b1;
          acc_o        = '0;
        end
        3'd4: acc_o = acc_i | hi_ext;
        3'd5: acc_o = hi_ext;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dkc_addr_reg.sv
module dkc_addr_reg #(
  parameter int LO_W     = 12,
  parameter int HI_W     = 8,
  parameter int PLAT_W   = 2,
  parameter int PLAT_LSB = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_lo_i,
  input  logic                 or_lo_i,
  input  logic                 clr_hi_i,
  input  logic                 or_hi_i,
  input  logic [LO_W-1:0]      acc_i,
  input  logic [PLAT_W-1:0]    plat_sel_i,
  output logic [LO_W+HI_W-1:0] da_o,
  output logic                 nodisk_nxt_o
);
  localparam int ADDR_W = LO_W + HI_W;
  localparam int CAP_W  = ADDR_W + 1;

  logic [LO_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CAP_W-1:0] cap;

  always_comb begin
    lo_d = clr_lo_i ? '0 : lo_q;
    if (or_lo_i) lo_d = lo_d | acc_i;
    hi_d = clr_hi_i ? '0 : hi_q;
    if (or_hi_i) hi_d = hi_d | acc_i[HI_W-1:0];
  end

  assign cap          = (CAP_W'(plat_sel_i) + CAP_W'(1)) << PLAT_LSB;
  assign nodisk_nxt_o = {1'b0, hi_d, lo_d} >= cap;
  assign da_o         = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/dkc_status_reg.sv
module dkc_status_reg
  import dkc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_errdone_i,
  input  logic             clr_en_i,
  input  logic             ld_en_i,
  input  logic             chk_cap_i,
  input  logic [5:0]       en_val_i,
  input  logic             nodisk_nxt_i,
  input  logic             pcell_i,
  input  logic             err_wlock_i,
  input  logic             err_late_i,
  input  logic             err_nodisk_i,
  input  logic             err_parity_i,
  input  logic             done_set_i,
  output logic [STA_W-1:0] sta_o,
  output logic             done_o,
  output logic             irq_o
);
  localparam int N_STK = 3;

  logic             pcell_q;
  logic [5:0]       en_q, en_d;
  logic [N_STK-1:0] stk_q, stk_d, stk_set;
  logic             nodisk_q, nodisk_d;
  logic             done_q, done_d;
  logic             err_any;

  // sticky errors: 2 = write lock, 1 = data late, 0 = parity
  assign stk_set = {err_wlock_i, err_late_i, err_parity_i};

  for (genvar i = 0; i < N_STK; i++) begin : g_stk
    assign stk_d[i] = (clr_errdone_i ? 1'b0 : stk_q[i]) | stk_set[i];
  end

  always_comb begin
    en_d = en_q;
    if (clr_en_i)     en_d = '0;
    else if (ld_en_i) en_d = en_val_i;
    nodisk_d = chk_cap_i ? nodisk_nxt_i : (clr_errdone_i ? 1'b0 : nodisk_q);
    nodisk_d = nodisk_d | err_nodisk_i;
    done_d   = (clr_errdone_i ? 1'b0 : done_q) | done_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcell_q  <= 1'b0;
      en_q     <= '0;
      stk_q    <= '0;
      nodisk_q <= 1'b0;
      done_q   <= 1'b1;
    end else begin
      pcell_q  <= pcell_i;
      en_q     <= en_d;
      stk_q    <= stk_d;
      nodisk_q <= nodisk_d;
      done_q   <= done_d;
    end
  end

  assign sta_o  = {pcell_q, 1'b0, stk_q[2], en_q, stk_q[1], nodisk_q, stk_q[0]};
  assign done_o = done_q;
  assign err_any = |(sta_o & ERR_MASK);
  assign irq_o  = (done_q && sta_o[B_EN_DN]) ||
                  (err_any && sta_o[B_EN_ERR]) ||
                  (pcell_q && sta_o[B_EN_PC]);
endmodule

// File: rtl/dkc_status_ctl.sv
module dkc_status_ctl
  import dkc_pkg::*;
#(
  parameter int WORD_W  = 11,
  parameter int TRACK_W = 7,
  parameter int PLAT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        sel_i,
  input  logic [2:0]        pulse_i,
  input  logic [STA_W-1:0]  acc_i,
  input  logic [PLAT_W-1:0] plat_sel_i,
  input  logic [WORD_W-1:0] rot_pos_i,
  input  logic              pcell_i,
  input  logic              err_wlock_i,
  input  logic              err_late_i,
  input  logic              err_nodisk_i,
  input  logic              err_parity_i,
  input  logic              done_set_i,
  output logic [STA_W-1:0]  acc_o,
  output logic              skip_o,
  output logic              start_o,
  output logic [2:0]        func_o,
  output logic              irq_o
);
  localparam int ADDR_W   = WORD_W + TRACK_W + PLAT_W;
  localparam int LO_W     = STA_W;
  localparam int HI_W     = ADDR_W - LO_W;
  localparam int PLAT_LSB = WORD_W + TRACK_W;

  ctl_t              ctl;
  logic [ADDR_W-1:0] da;
  logic [STA_W-1:0]  sta;
  logic              done;
  logic              nodisk_nxt;
  logic              pos_match;
  logic              start_q;
  logic [2:0]        func_q;

  assign pos_match = (da[WORD_W-1:0] == rot_pos_i);

  dkc_pulse_dec #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
    .sel_i       (sel_i),
    .pulse_i     (pulse_i),
    .acc_i       (acc_i),
    .sta_i       (sta),
    .done_i      (done),
    .da_lo_i     (da[LO_W-1:0]),
    .da_hi_i     (da[ADDR_W-1:LO_W]),
    .pos_match_i (pos_match),
    .ctl_o       (ctl),
    .acc_o       (acc_o),
    .skip_o      (skip_o)
  );

  dkc_addr_reg #(
    .LO_W(LO_W), .HI_W(HI_W), .PLAT_W(PLAT_W), .PLAT_LSB(PLAT_LSB)
  ) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_lo_i     (ctl.clr_lo),
    .or_lo_i      (ctl.or_lo),
    .clr_hi_i     (ctl.clr_hi),
    .or_hi_i      (ctl.or_hi),
    .acc_i        (acc_i),
    .plat_sel_i   (plat_sel_i),
    .da_o         (da),
    .nodisk_nxt_o (nodisk_nxt)
  );

  dkc_status_reg u_sta (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_errdone_i (ctl.clr_errdone),
    .clr_en_i      (ctl.clr_en),
    .ld_en_i       (ctl.ld_en),
    .chk_cap_i     (ctl.chk_cap),
    .en_val_i      (acc_i[8:3]),
    .nodisk_nxt_i  (nodisk_nxt),
    .pcell_i       (pcell_i),
    .err_wlock_i   (err_wlock_i),
    .err_late_i    (err_late_i),
    .err_nodisk_i  (err_nodisk_i),
    .err_parity_i  (err_parity_i),
    .done_set_i    (done_set_i),
    .sta_o         (sta),
    .done_o        (done),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      func_q  <= '0;
    end else begin
      start_q <= ctl.start;
      if (ctl.start) func_q <= ctl.func;
    end
  end

  assign start_o = start_q;
  assign func_o  = func_q;
endmodule

// File: rtl/dkc_status_ctl_chk.sv
module dkc_status_ctl_chk #(
  parameter int WORD_W  = 11,
  parameter int TRACK_W = 7,
  parameter int PLAT_W  = 2
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [3:0]                       sel_i,
  input logic [2:0]                       pulse_i,
  input logic [11:0]                      acc_i,
  input logic [11:0]                      acc_o,
  input logic                             skip_o,
  input logic                             start_o,
  input logic [2:0]                       func_o,
  input logic                             irq_o,
  input logic                             pcell_i,
  input logic                             err_nodisk_i,
  input logic                             done_set_i,
  input logic [PLAT_W-1:0]                plat_sel_i,
  input logic                             sta_pcell,
  input logic                             sta_nodisk,
  input logic                             done,
  input logic [WORD_W+TRACK_W+PLAT_W-1:0] da
);
  localparam int ADDR_W = WORD_W + TRACK_W + PLAT_W;
  localparam int CAP_W  = ADDR_W + 1;

  logic             seen_q;
  logic [CAP_W-1:0] cap;

  assign cap = (CAP_W'(plat_sel_i) + CAP_W'(1)) << (WORD_W + TRACK_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_sel_onehot_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  p_idle_pass_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0000) |-> (acc_o == acc_i && !skip_o));

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0001 && (pulse_i[1] || pulse_i[2])) |=>
      (start_o && func_o == {$past(pulse_i[2]), $past(pulse_i[1]), 1'b0}));

  p_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i[0] && (pulse_i[1] || pulse_i[2])) |=> !start_o);

  p_clr_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0001 && pulse_i[0] && !done_set_i) |=> !done);

  p_irq_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0010 && pulse_i == 3'd1) |=> !irq_o);

  p_ld_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b0010 && pulse_i == 3'd5) |-> (acc_o == 12'd0));

  p_nodisk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 4'b1000 && !err_nodisk_i) |=>
      (sta_nodisk == ({1'b0, da} >= $past(cap))));

  p_pcell_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (sta_pcell == $past(pcell_i)));
endmodule

bind dkc_status_ctl dkc_status_ctl_chk #(
  .WORD_W(WORD_W), .TRACK_W(TRACK_W), .PLAT_W(PLAT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .pulse_i      (pulse_i),
  .acc_i        (acc_i),
  .acc_o        (acc_o),
  .skip_o       (skip_o),
  .start_o      (start_o),
  .func_o       (func_o),
  .irq_o        (irq_o),
  .pcell_i      (pcell_i),
  .err_nodisk_i (err_nodisk_i),
  .done_set_i   (done_set_i),
  .plat_sel_i   (plat_sel_i),
  .sta_pcell    (sta[11]),
  .sta_nodisk   (sta[1]),
  .done         (done),
  .da           (da)
);

// File: tb/dkc_status_ctl_bench.sv
module dkc_status_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic [2:0]  pulse_v = '0;
  logic [11:0] acc = '0;
  logic [1:0]  plat = '0;
  logic [10:0] rot = '0;
  logic        pcell = 1'b0;
  logic        e_wl = 1'b0, e_lt = 1'b0, e_nd = 1'b0, e_pr = 1'b0, d_set = 1'b0;
  logic [11:0] acc_o;
  logic        skip_o, start_o, irq_o;
  logic [2:0]  func_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [11:0] r_acc;
  logic        r_skip, r_start;
  logic [2:0]  r_func;

  always #4 clk = ~clk;

  dkc_status_ctl u_dkc_status_ctl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .pulse_i(pulse_v), .acc_i(acc),
    .plat_sel_i(plat), .rot_pos_i(rot), .pcell_i(pcell),
    .err_wlock_i(e_wl), .err_late_i(e_lt), .err_nodisk_i(e_nd), .err_parity_i(e_pr),
    .done_set_i(d_set), .acc_o(acc_o), .skip_o(skip_o), .start_o(start_o),
    .func_o(func_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  // g = 0..3 selects a group, 4 = none; stb = {done, nodisk, parity, late, wlock}
  task automatic pulse(input int g, input logic [2:0] p, input logic [11:0] a,
                       input logic [4:0] stb);
    @(negedge clk);
    sel = (g < 4) ? 4'(1 << g) : 4'b0000;
    pulse_v = p;
    acc = a;
    {d_set, e_nd, e_pr, e_lt, e_wl} = stb;
    #1;
    r_acc = acc_o;
    r_skip = skip_o;
    @(posedge clk);
    #1;
    r_start = start_o;
    r_func = func_o;
    sel = '0; pulse_v = '0; acc = '0;
    {d_set, e_nd, e_pr, e_lt, e_wl} = '0;
  endtask

  task automatic rd_sta(output logic [11:0] v);
    pulse(1, 3'd6, 12'o0, 5'b0);
    v = r_acc;
  endtask

  task automatic rd_done(output logic v);
    pulse(2, 3'd2, 12'o0, 5'b0);
    v = r_skip;
  endtask

  logic [11:0] v;
  logic        b;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk("R1 irq", irq_o, 0);
    rd_sta(v);                       chk("R1 status", v, 12'o0);
    pulse(2, 3'd4, 12'o7777, 5'b0);  chk("R1 low addr", r_acc, 12'o0);
    pulse(3, 3'd5, 12'o7777, 5'b0);  chk("R1 high addr", r_acc, 12'o0);
    rd_done(b);                      chk("R1 done", b, 1);

    // R2 clear, R3 load and start
    pulse(0, 3'd1, 12'o0, 5'b0);
    rd_done(b);                      chk("R2 done cleared", b, 0);
    pulse(0, 3'd2, 12'o0123, 5'b0);
    chk("R3 acc zero", r_acc, 12'o0);
    chk("R3 start", r_start, 1);
    chk("R3 func read", r_func, 3'd2);
    pulse(4, 3'd0, 12'o0, 5'b0);     chk("R3 start one cycle", r_start, 0);
    pulse(0, 3'd4, 12'o4000, 5'b0);
    chk("R3 func write", r_func, 3'd4);
    pulse(2, 3'd4, 12'o0, 5'b0);     chk("R3 or low", r_acc, 12'o4123);
    pulse(2, 3'd6, 12'o7777, 5'b0);  chk("R7 read low no done skip", r_acc, 12'o4123);
    chk("R7 no skip with bit2", r_skip, 0);

    // R12 strobes set, R2 clear errors
    pulse(4, 3'd0, 12'o0, 5'b11111);
    rd_sta(v);                       chk("R12 errors set", v, 12'o1007);
    pulse(2, 3'd1, 12'o0, 5'b0);     chk("R7 error skip", r_skip, 1);
    pulse(2, 3'd3, 12'o0, 5'b0);     chk("R7 error or done skip", r_skip, 1);
    pulse(0, 3'd1, 12'o0, 5'b0);
    rd_sta(v);                       chk("R2 errors cleared", v, 12'o0);
    pulse(2, 3'd4, 12'o0, 5'b0);     chk("R2 low cleared", r_acc, 12'o0);
    pulse(2, 3'd1, 12'o0, 5'b0);     chk("R7 no error skip", r_skip, 0);
    pulse(0, 3'd1, 12'o0, 5'b10100);
    rd_sta(v);                       chk("R12 parity wins over clear", v, 12'o0001);
    rd_done(b);                      chk("R12 done wins over clear", b, 1);

    // R5 load / read enables, R10, R4
    pulse(1, 3'd5, 12'o7777, 5'b0);  chk("R5 load returns zero", r_acc, 12'o0);
    chk("R10 done irq", irq_o, 1);
    rd_sta(v);                       chk("R5 status", v, 12'o0771);
    pulse(1, 3'd1, 12'o5555, 5'b0);  chk("R4 acc pass", r_acc, 12'o5555);
    chk("R4 irq low", irq_o, 0);
    rd_sta(v);                       chk("R4 keep others", v, 12'o0001);

    // R10 sweep of enables and sources
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        logic exp_irq;
        pulse(0, 3'd1, 12'o0, 5'b0);
        pcell = s[2];
        pulse(4, 3'd0, 12'o0, {s[0], 1'b0, s[1], 2'b00});
        pulse(1, 3'd5, 12'(e << 6), 5'b0);
        exp_irq = (s[0] && e[0]) || (s[1] && e[2]) || (s[2] && e[1]);
        chk($sformatf("R10 irq en=%0d src=%0d", e, s), irq_o, exp_irq);
      end
    end
    pulse(1, 3'd1, 12'o0, 5'b0);

    // R11 photocell bit
    pcell = 1'b1;
    pulse(4, 3'd0, 12'o0, 5'b0);
    rd_sta(v);                       chk("R11 pcell set", v[11], 1);
    pcell = 1'b0;
    pulse(4, 3'd0, 12'o0, 5'b0);
    rd_sta(v);                       chk("R11 pcell clear", v[11], 0);

    // R6 full rotational sweep; address bit 11 ignored
    pulse(0, 3'd1, 12'o0, 5'b0);
    pulse(0, 3'd2, 12'o5432, 5'b0);
    for (int r = 0; r < 2048; r++) begin
      rot = 11'(r);
      pulse(1, 3'd2, 12'o0, 5'b0);
      chk($sformatf("R6 pos %0o", r), r_skip, (r == 11'o1432));
    end

    // R8 / R9 sweep of high address against each capacity
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 256; h++) begin
        plat = 2'(p);
        pulse(3, 3'd3, 12'hF00 | 12'(h), 5'b0);
        chk("R8 replace returns zero", r_acc, 12'o0);
        pulse(3, 3'd5, 12'hABC, 5'b0);
        chk("R8 read high", r_acc, 12'(h));
        rd_sta(v);
        chk($sformatf("R9 nodisk plat=%0d h=%0d", p, h), v[1], ((h >> 6) > p));
      end
    end

    pulse(3, 3'd1, 12'o0, 5'b0);
    pulse(3, 3'd5, 12'o0, 5'b0);     chk("R8 clear high", r_acc, 12'o0);
    pulse(3, 3'd2, 12'h0A5, 5'b0);   chk("R8 or returns zero", r_acc, 12'o0);
    pulse(3, 3'd2, 12'h050, 5'b0);
    pulse(3, 3'd4, 12'o7000, 5'b0);  chk("R8 or into acc", r_acc, 12'o7000 | 12'h0F5);
    pulse(0, 3'd1, 12'o0, 5'b0);
    rd_sta(v);                       chk("R2 nodisk cleared", v[1], 0);
    plat = 2'd3;
    pulse(3, 3'd0, 12'o0, 5'b0);
    plat = 2'd0;
    pulse(4, 3'd0, 12'o0, 5'b0);
    rd_sta(v);                       chk("R9 no update without pulse", v[1], 0);
    pulse(3, 3'd7, 12'o1234, 5'b0);  chk("R13 group3 pulse7 pass", r_acc, 12'o1234);
    rd_sta(v);                       chk("R9 update on pulse", v[1], 1);

    // R13 unselected and undecoded pulses
    pulse(4, 3'd6, 12'o1234, 5'b0);  chk("R13 idle acc", r_acc, 12'o1234);
    chk("R13 idle skip", r_skip, 0);
    pulse(2, 3'd0, 12'o4321, 5'b0);  chk("R13 group2 pulse0", r_acc, 12'o4321);
    chk("R13 group2 pulse0 skip", r_skip, 0);
    pulse(1, 3'd3, 12'o0777, 5'b0);  chk("R13 group1 pulse3", r_acc, 12'o0777);
    pulse(0, 3'd0, 12'o7777, 5'b0);  chk("R13 group0 pulse0", r_acc, 12'o7777);
    rd_sta(v);                       chk("R13 status unchanged", v, 12'o0002);
    pulse(2, 3'd4, 12'o0, 5'b0);     chk("R13 low unchanged", r_acc, 12'o0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule